// File: doc/BRIEF.md
# Register-Width and Processor-Mode Controller

This block keeps the width-select flags of a 16-bit-capable processor core, the emulation/native mode flag, and the stack pointer, both index registers and the accumulator as 16-bit values. The decoder gives it single-cycle strobes for the clear-flags, set-flags and pull-flags operations, each with an 8-bit operand. A separate strobe swaps the carry flag with the mode flag. Register writes arrive as strobes with a shared 16-bit data word. The accumulator-width flag M sits at bit 5 and the index-width flag X at bit 4.

Every write and every flag change passes through one rule. While X is 1, the high bytes of both index registers are zero. While the core is in emulation mode, M and X are 1 and the high byte of the stack pointer is 0x01. Entering emulation therefore truncates the index registers and relocates the stack page. Leaving emulation changes no register.

A multiplexed status pin shows M while the clock phase is low and X while it is high. A valid qualifier drops for the one cycle after any clear, set or pull of the flags, because that cycle is the next opcode fetch.

Top module: `mode_width_ctl`

## Requirements
- R1: In native mode, a clear strobe makes every status bit that is 1 in the operand read 0 after the next clock. The other bits keep their values.
- R2: A set strobe makes every status bit that is 1 in the operand read 1 after the next clock. The other bits keep their values.
- R3: In native mode, a pull strobe loads the whole operand into the status byte.
- R4: In emulation mode, bit 5 (M) and bit 4 (X) stay 1 after any clear, set or pull strobe.
- R5: An exchange strobe moves status bit 0 (carry) into the mode flag, where 1 means emulation, and moves the old mode flag into bit 0. When the mode goes from native to emulation, M and X become 1, the stack high byte becomes 0x01, and the X and Y high bytes become 0x00.
- R6: An exchange keeps the low bytes of S, X and Y and the whole accumulator. An exchange from emulation to native changes no register.
- R7: `mx_pin` equals M while `phi2` is 0 and X while `phi2` is 1.
- R8: `mx_valid` is 0 for exactly the one cycle after a clear, set or pull strobe. Otherwise it is 1, including after an exchange.
- R9: While X is 1, a write to the X or Y register stores 0x00 in its high byte. A set strobe that makes X equal 1 clears both index high bytes.
- R10: In emulation mode, a write to S stores 0x01 in its high byte.
- R11: After reset the block is in emulation mode, the status byte is 0x30, S is 0x0100, and X, Y and A are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phi2 | input | 1 | Clock phase that selects the pin source |
| rep_stb | input | 1 | Clear the status bits marked in the operand |
| sep_stb | input | 1 | Set the status bits marked in the operand |
| plp_stb | input | 1 | Load the status byte from the operand |
| xce_stb | input | 1 | Swap carry with the mode flag |
| flag_opnd | input | 8 | Operand for the flag strobes |
| wr_s | input | 1 | Write the stack pointer |
| wr_x | input | 1 | Write index X |
| wr_y | input | 1 | Write index Y |
| wr_a | input | 1 | Write the accumulator |
| wr_data | input | 16 | Write data |
| status | output | 8 | Status byte |
| emu | output | 1 | Emulation mode flag |
| s_reg | output | 16 | Stack pointer |
| x_reg | output | 16 | Index X |
| y_reg | output | 16 | Index Y |
| a_reg | output | 16 | Accumulator (B high, A low) |
| mx_pin | output | 1 | M or X, selected by phase |
| mx_valid | output | 1 | Qualifier for `mx_pin` |

## Verification
The clocked properties assume that at most one of the four flag strobes is active in any cycle. They also assume that no register write comes in the same cycle as an exchange, so that "the low bytes are kept" has one meaning. The directed tasks raise one strobe per cycle and lower it at the next falling edge, so they stay inside these limits. The register writes sit in their own cycles, away from every flag operation.

// File: rtl/mode_width_ctl.sv
module mode_width_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phi2,
  input  logic        rep_stb,
  input  logic        sep_stb,
  input  logic        plp_stb,
  input  logic        xce_stb,
  input  logic [7:0]  flag_opnd,
  input  logic        wr_s,
  input  logic        wr_x,
  input  logic        wr_y,
  input  logic        wr_a,
  input  logic [15:0] wr_data,
  output logic [7:0]  status,
  output logic        emu,
  output logic [15:0] s_reg,
  output logic [15:0] x_reg,
  output logic [15:0] y_reg,
  output logic [15:0] a_reg,
  output logic        mx_pin,
  output logic        mx_valid
);
  localparam int MB = 5;
  localparam int XB = 4;
  localparam int CB = 0;
  localparam logic [7:0] STACK_PAGE = 8'h01;

  logic [7:0]  st_n;
  logic        emu_n;
  logic [15:0] s_n, x_n, y_n, a_n;
  logic        flag_op, mx_hold;

  assign flag_op = rep_stb | sep_stb | plp_stb;

  always_comb begin
    st_n  = status;
    emu_n = emu;
    if (rep_stb)      st_n = status & ~flag_opnd;
    else if (sep_stb) st_n = status | flag_opnd;
    else if (plp_stb) st_n = flag_opnd;
    if (xce_stb) begin
      emu_n    = status[CB];
      st_n[CB] = emu;
    end
    if (emu_n) begin
      st_n[MB] = 1'b1;
      st_n[XB] = 1'b1;
    end
    s_n = wr_s ? wr_data : s_reg;
    x_n = wr_x ? wr_data : x_reg;
    y_n = wr_y ? wr_data : y_reg;
    a_n = wr_a ? wr_data : a_reg;
    if (st_n[XB]) begin
      x_n[15:8] = 8'h00;
      y_n[15:8] = 8'h00;
    end
    if (emu_n) s_n[15:8] = STACK_PAGE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 8'h30;
      emu     <= 1'b1;
      s_reg   <= {STACK_PAGE, 8'h00};
      x_reg   <= '0;
      y_reg   <= '0;
      a_reg   <= '0;
      mx_hold <= 1'b0;
    end else begin
      status  <= st_n;
      emu     <= emu_n;
      s_reg   <= s_n;
      x_reg   <= x_n;
      y_reg   <= y_n;
      a_reg   <= a_n;
      mx_hold <= flag_op;
    end
  end

  assign mx_pin   = phi2 ? status[XB] : status[MB];
  assign mx_valid = ~mx_hold;

  AST_REP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_stb && !emu && !xce_stb) |=> ((status & $past(flag_opnd)) == 8'h00)); // R1
  AST_SEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sep_stb && !xce_stb) |=> ((status & $past(flag_opnd)) == $past(flag_opnd))); // R2
  AST_EMU_WIDTH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (emu && flag_op) |=> (status[MB] && status[XB])); // R4
  AST_ENTRY_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu) |-> (s_reg[15:8] == STACK_PAGE && x_reg[15:8] == 8'h00 && y_reg[15:8] == 8'h00)); // R5
  AST_XCE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xce_stb && !(wr_s || wr_x || wr_y || wr_a)) |=>
      (s_reg[7:0] == $past(s_reg[7:0]) && x_reg[7:0] == $past(x_reg[7:0]) &&
       y_reg[7:0] == $past(y_reg[7:0]) && a_reg == $past(a_reg))); // R6
  AST_MX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> !mx_valid); // R8
  AST_MX_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_op |=> mx_valid); // R8
  AST_IDX_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_x || wr_y) && status[XB] && !rep_stb && !plp_stb) |=> (x_reg[15:8] == 8'h00 && y_reg[15:8] == 8'h00)); // R9
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && emu && !xce_stb) |=> (s_reg[15:8] == STACK_PAGE)); // R10
endmodule

// File: tb/mode_width_ctl_test.sv
module mode_width_ctl_test;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, phi2 = 1'b0;
  logic rep_stb = 0, sep_stb = 0, plp_stb = 0, xce_stb = 0;
  logic [7:0] flag_opnd = '0;
  logic wr_s = 0, wr_x = 0, wr_y = 0, wr_a = 0;
  logic [15:0] wr_data = '0;
  logic [7:0] status;
  logic emu, mx_pin, mx_valid;
  logic [15:0] s_reg, x_reg, y_reg, a_reg;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_width_ctl uut (.clk(clk), .rst_n(rst_n), .phi2(phi2), .rep_stb(rep_stb), .sep_stb(sep_stb),
    .plp_stb(plp_stb), .xce_stb(xce_stb), .flag_opnd(flag_opnd), .wr_s(wr_s), .wr_x(wr_x),
    .wr_y(wr_y), .wr_a(wr_a), .wr_data(wr_data), .status(status), .emu(emu), .s_reg(s_reg),
    .x_reg(x_reg), .y_reg(y_reg), .a_reg(a_reg), .mx_pin(mx_pin), .mx_valid(mx_valid));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic flag_op(int kind, logic [7:0] opnd);
    @(negedge clk);
    flag_opnd = opnd;
    rep_stb = (kind == 0); sep_stb = (kind == 1); plp_stb = (kind == 2); xce_stb = (kind == 3);
    @(negedge clk);
    rep_stb = 0; sep_stb = 0; plp_stb = 0; xce_stb = 0;
  endtask

  task automatic write_reg(int which, logic [15:0] d);
    @(negedge clk);
    wr_data = d;
    wr_s = (which == 0); wr_x = (which == 1); wr_y = (which == 2); wr_a = (which == 3);
    @(negedge clk);
    wr_s = 0; wr_x = 0; wr_y = 0; wr_a = 0;
  endtask

  task automatic t_reset;
    chk("R11 status", {8'h0, status}, 16'h0030);
    chk("R11 emu", {15'h0, emu}, 16'h1);
    chk("R11 S", s_reg, 16'h0100);
    chk("R11 X", x_reg, 16'h0000);
    chk("R11 Y", y_reg, 16'h0000);
    chk("R11 A", a_reg, 16'h0000);
    chk("R8 valid idle", {15'h0, mx_valid}, 16'h1);
  endtask

  task automatic t_emu_rep;
    flag_op(0, 8'h30);
    chk("R4 rep in emu", {8'h0, status}, 16'h0030);
    chk("R8 rep pulse", {15'h0, mx_valid}, 16'h0);
    @(negedge clk);
    chk("R8 rep recover", {15'h0, mx_valid}, 16'h1);
    flag_op(2, 8'h00);
    chk("R4 plp in emu", {8'h0, status}, 16'h0030);
    chk("R8 plp pulse", {15'h0, mx_valid}, 16'h0);
  endtask

  task automatic t_emu_writes;
    write_reg(0, 16'hFFAB);
    chk("R10 S page", s_reg, 16'h01AB);
    write_reg(1, 16'h1234);
    chk("R9 X trunc", x_reg, 16'h0034);
  endtask

  task automatic t_to_native;
    flag_op(3, 8'h00);
    chk("R5 emu cleared", {15'h0, emu}, 16'h0);
    chk("R5 carry gets emu", {8'h0, status}, 16'h0031);
    chk("R6 S kept", s_reg, 16'h01AB);
    chk("R6 X kept", x_reg, 16'h0034);
    chk("R8 xce no pulse", {15'h0, mx_valid}, 16'h1);
  endtask

  task automatic t_native_flags;
    flag_op(0, 8'h30);
    chk("R1 rep native", {8'h0, status}, 16'h0001);
    chk("R8 rep pulse native", {15'h0, mx_valid}, 16'h0);
    write_reg(1, 16'hBEEF); write_reg(2, 16'hCAFE);
    write_reg(0, 16'h2345); write_reg(3, 16'h5A5A);
    chk("R9 X wide", x_reg, 16'hBEEF);
    chk("R10 S native", s_reg, 16'h2345);
    flag_op(1, 8'h10);
    chk("R2 sep", {8'h0, status}, 16'h0011);
    chk("R8 sep pulse", {15'h0, mx_valid}, 16'h0);
    chk("R9 sep clears X hi", x_reg, 16'h00EF);
    chk("R9 sep clears Y hi", y_reg, 16'h00FE);
    flag_op(0, 8'h10);
    write_reg(1, 16'hBEEF); write_reg(2, 16'hCAFE);
    flag_op(2, 8'hC2);
    chk("R3 plp native", {8'h0, status}, 16'h00C2);
    chk("R8 plp pulse native", {15'h0, mx_valid}, 16'h0);
  endtask

  task automatic t_pin;
    flag_op(2, 8'h20);
    phi2 = 0; #1;
    chk("R7 pin M", {15'h0, mx_pin}, 16'h1);
    phi2 = 1; #1;
    chk("R7 pin X", {15'h0, mx_pin}, 16'h0);
    phi2 = 0;
  endtask

  task automatic t_to_emu;
    flag_op(1, 8'h01);
    flag_op(3, 8'h00);
    chk("R5 emu set", {15'h0, emu}, 16'h1);
    chk("R5 flags forced", {8'h0, status}, 16'h0030);
    chk("R5 S page", s_reg, 16'h0145);
    chk("R5 X hi", x_reg, 16'h00EF);
    chk("R5 Y hi", y_reg, 16'h00FE);
    chk("R6 A kept", a_reg, 16'h5A5A);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_emu_rep;
    t_emu_writes;
    t_to_native;
    t_native_flags;
    t_pin;
    t_to_emu;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule